// File: doc/BRIEF.md
# Ring-Oscillator Parity Accumulator

This block turns a large set of free-running ring oscillators into a 32-bit random word. Each ring is an odd loop of three inverting stages, so it never settles. Its output reaches the block as an asynchronous input bit. Every bit of the output word owns a group of fifteen rings. On each rising edge of the bus clock (nominally 50 MHz), every ring is resynchronised through two flops. Each accumulator bit is then replaced by its own old value XORed with the fifteen fresh samples of its group.

Accumulation runs on every clock and never waits for a reader. The longer a host waits between reads, the more samples are folded into each bit. At 25 clocks between reads that is 375 samples per bit, and at 50 clocks it is 750. A host fetches the word through a one-cycle read port.

A counter reports how many clocks have passed since the last read, so software can refuse a word that has seen too few samples. The read port is a two-state machine. RD_IDLE moves to RD_DRIVE when the strobe is seen and stays in RD_IDLE otherwise. RD_DRIVE moves back to RD_IDLE when no strobe is seen, and stays in RD_DRIVE on a back-to-back strobe. The valid flag is high exactly in RD_DRIVE.

Top module: `osc_xor_pool`

## Requirements
- R1: Ring input bit `ring_in[b*15 + k]`, for k in 0..14, belongs to the group of output bit b; no ring affects any other bit.
- R2: A ring value present at clock edge n is folded into the accumulator at edge n+2. A read strobed at edge j therefore returns the parity of all values captured at edges up to j-3.
- R3: On every clock out of reset, each accumulator bit becomes its old value XOR the parity of its group's fifteen synchronised samples. With all rings high, every bit toggles every clock. With all rings low, every bit holds.
- R4: A synchronous active-high reset clears the synchronisers, the accumulator, the read data, the valid flag and the sample counter to zero.
- R5: When `rd_stb` is high at an edge, `rd_data` presents the accumulator word held before that edge, and `rd_valid` is high for the following cycle only. Without a strobe, `rd_valid` is low and `rd_data` holds.
- R6: Reads, including back-to-back strobes, neither clear nor alter the accumulation.
- R7: `sample_count` goes to zero at an edge with `rd_stb` high, and otherwise rises by one per clock.
- R8: `sample_count` saturates at 2^CNT_W-1 (255 by default) and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in | input | NUM_BITS*RINGS_PER_BIT (480) | Asynchronous ring oscillator outputs, grouped by output bit |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | NUM_BITS (32) | Accumulated random word from the last read |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| sample_count | output | CNT_W (8) | Clocks since the last read, saturating |

## Verification
The bench goes after the two-flop delay by pulsing one ring for one clock and reading on the edges around its arrival. A design with one flop too few or too many would show the bit a cycle early or late. It drives all-high rings, where an accumulator that dropped its feedback term would stick at one instead of toggling. It drives single rings at chosen positions, where a mis-sliced group would light the wrong bit. Back-to-back reads, a counter run past 255 and a reset in mid-stream catch a read that clears the word, a counter that wraps to zero, and state that survives reset.

// File: rtl/osc_pool_pkg.sv
package osc_pool_pkg;

    // Read port sequencing
    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_DRIVE = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ring_sync.sv
// Two-stage resynchroniser for a vector of asynchronous ring outputs.
module ring_sync #(
    parameter int WIDTH = 480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/xor_fold_cell.sv
// One output bit: feedback parity accumulator over one ring group.
module xor_fold_cell #(
    parameter int RINGS = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RINGS-1:0] samples,
    output logic             acc_bit
);

    logic acc_q;
    logic group_par;

    always_comb begin
        group_par = ^samples;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= acc_q ^ group_par;
        end
    end

    assign acc_bit = acc_q;

endmodule

// File: rtl/mix_counter.sv
// Counts clocks since the last read; saturates at all-ones.
module mix_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/osc_xor_pool.sv
module osc_xor_pool
    import osc_pool_pkg::*;
#(
    parameter int NUM_BITS      = 32,
    parameter int RINGS_PER_BIT = 15,
    parameter int CNT_W         = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BITS*RINGS_PER_BIT-1:0] ring_in,
    input  logic                              rd_stb,
    output logic [NUM_BITS-1:0]               rd_data,
    output logic                              rd_valid,
    output logic [CNT_W-1:0]                  sample_count
);

    localparam int RING_TOTAL = NUM_BITS * RINGS_PER_BIT;

    logic [RING_TOTAL-1:0] ring_sync_w;
    logic [NUM_BITS-1:0]   acc_word;
    logic [NUM_BITS-1:0]   rd_data_q;
    rd_state_e             state_q;
    rd_state_e             state_d;

    ring_sync #(.WIDTH(RING_TOTAL)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ring_in),
        .sync_out (ring_sync_w)
    );

    for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
        xor_fold_cell #(.RINGS(RINGS_PER_BIT)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .samples (ring_sync_w[b*RINGS_PER_BIT +: RINGS_PER_BIT]),
            .acc_bit (acc_word[b])
        );
    end

    mix_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (rd_stb),
        .count (sample_count)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  state_d = rd_stb ? RD_DRIVE : RD_IDLE;
            RD_DRIVE: state_d = rd_stb ? RD_DRIVE : RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    // State register and read data
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RD_IDLE;
            rd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_stb) begin
                rd_data_q <= acc_word;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_valid = (state_q == RD_DRIVE);
        rd_data  = rd_data_q;
    end

endmodule

// File: rtl/osc_xor_pool_chk.sv
module osc_xor_pool_chk #(
    parameter int NUM_BITS = 32,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_stb,
    input logic                rd_valid,
    input logic [NUM_BITS-1:0] rd_data,
    input logic [CNT_W-1:0]    sample_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R4
    a_r4_reset_clears: assert property (@(posedge clk)
        rst |=> (sample_count == '0 && !rd_valid && rd_data == '0));

    // R5
    a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);

    // R5
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);

    // R7
    a_r7_count_cleared: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> sample_count == '0);

    // R7
    a_r7_count_steps: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && sample_count != CNT_MAX) |=>
            sample_count == CNT_W'($past(sample_count) + CNT_W'(1)));

    // R8
    a_r8_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && sample_count == CNT_MAX) |=> sample_count == CNT_MAX);

endmodule

bind osc_xor_pool osc_xor_pool_chk #(
    .NUM_BITS (NUM_BITS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_stb       (rd_stb),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .sample_count (sample_count)
);

// File: tb/osc_xor_pool_tb.sv
module osc_xor_pool_tb;

    localparam int NB   = 32;
    localparam int RP   = 15;
    localparam int W    = NB * RP;
    localparam int CW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    typedef struct {
        logic          valid;
        logic [NB-1:0] word;
        int            cnt;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  ring = '0;
    logic          rd_stb = 1'b0;
    logic [NB-1:0] rd_data;
    logic          rd_valid;
    logic [CW-1:0] sample_count;

    int            n_checks = 0;
    int            n_fails  = 0;
    logic [NB-1:0] ph[$];
    exp_t          exp_q[$];
    int            cnt_model = 0;
    logic [NB-1:0] last_word = '0;

    always #2 clk = ~clk;

    osc_xor_pool #(.NUM_BITS(NB), .RINGS_PER_BIT(RP), .CNT_W(CW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .ring_in      (ring),
        .rd_stb       (rd_stb),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .sample_count (sample_count)
    );

    function automatic logic [NB-1:0] grp_par(input logic [W-1:0] v);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) p[b] = ^v[b*RP +: RP];
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: called at a negedge; applies one cycle and pushes the expectation
    task automatic cycle(input logic [W-1:0] v, input bit rd, input string tag);
        exp_t e;
        int   j;
        ring   = v;
        rd_stb = rd;
        ph.push_back(grp_par(v));
        j = ph.size() - 1;
        e.word = last_word;
        if (rd) begin
            e.word = '0;
            for (int i = 0; i <= j - 3; i++) e.word ^= ph[i];
            last_word = e.word;
        end
        cnt_model = rd ? 0 : ((cnt_model < MAXC) ? cnt_model + 1 : MAXC);
        e.valid = rd;
        e.cnt   = cnt_model;
        e.tag   = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(rd_valid == e.valid, (e.valid ? "R5" : "R5"), "rd_valid",
                  NB'(rd_valid), NB'(e.valid));
            check(rd_data == e.word, e.tag, "rd_data", rd_data, e.word);
            check(int'(sample_count) == e.cnt,
                  (e.cnt == MAXC) ? "R8" : "R7", "sample_count",
                  NB'(sample_count), NB'(e.cnt));
        end
    end

    task automatic do_reset();
        rst    = 1'b1;
        rd_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rd_valid == 1'b0, "R4", "rd_valid after reset", NB'(rd_valid), '0);
        check(sample_count == '0, "R4", "sample_count after reset", NB'(sample_count), '0);
        check(rd_data == '0, "R4", "rd_data after reset", rd_data, '0);
        ph.delete();
        cnt_model = 0;
        last_word = '0;
    endtask

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i += 32) v[i +: 32] = $urandom();
        return v;
    endfunction

    initial begin
        #(4 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R3: all rings low, word stays zero
        for (int k = 0; k < 12; k++) cycle('0, (k % 3) == 2, "R3");

        // R3: all rings high, every bit toggles each clock
        for (int k = 0; k < 20; k++) cycle('1, (k % 4) == 3, "R3");

        // R2: one-cycle pulse on ring 37, reads around its arrival
        cycle('0, 1'b0, "R2");
        cycle(W'(1) << 37, 1'b0, "R2");
        cycle('0, 1'b0, "R2");
        cycle('0, 1'b1, "R2");
        cycle('0, 1'b1, "R2");
        cycle('0, 1'b1, "R2");

        // R1: single ring per group, at varied positions
        for (int b = 0; b < NB; b += 5) begin
            cycle(W'(1) << (b*RP + (b % RP)), 1'b0, "R1");
            cycle('0, 1'b0, "R1");
            cycle('0, 1'b0, "R1");
            cycle('0, 1'b1, "R1");
        end

        // R3: one ring toggling every clock
        for (int k = 0; k < 20; k++)
            cycle((k % 2) ? (W'(1) << 200) : '0, (k % 5) == 4, "R3");

        // R3: random rings, occasional reads
        for (int k = 0; k < 60; k++) cycle(rand_vec(), ($urandom() % 4) == 0, "R3");

        // R6: back-to-back reads do not disturb accumulation
        for (int k = 0; k < 12; k++) cycle(rand_vec(), 1'b1, "R6");

        // R8: long gap saturates the counter, then a read
        for (int k = 0; k < 300; k++) cycle(rand_vec(), 1'b0, "R8");
        cycle(rand_vec(), 1'b1, "R8");
        cycle('0, 1'b0, "R7");

        // R4: reset mid-stream, then reads start from zero
        for (int k = 0; k < 5; k++) cycle('1, 1'b0, "R4");
        do_reset();
        for (int k = 0; k < 6; k++) cycle('0, 1'b1, "R4");

        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule